// File: doc/BRIEF.md
# Energy Bucket Accumulator Counter

This block turns per-interval average power results into whole energy counts. Each accepted transfer carries one signed power result and the number of samples in its accumulation interval. The block multiplies the magnitude of the power by the sample count to get the energy of that interval. It then adds that energy to one of two residual accumulators: one for energy flowing forward, one for energy flowing back. When a residual reaches the programmed bucket size, the block removes one bucket from it and advances the matching count register by one. The remainder stays in the residual, so no energy is lost between intervals.

The input is a valid/ready stream. The block stalls the producer while it is draining. It removes at most one bucket per lane per clock, so an interval worth several buckets keeps `in_ready` low for that many cycles. While `in_valid` is high and `in_ready` is low, the producer must hold the power and divisor steady. The transfer happens on the first rising edge where both are high. The bucket size is the concatenation of two configuration words. A synchronous clear zeroes both counters and both residuals.

Top module: `energy_bucket_counter`

## Requirements
- R1: An accepted transfer adds |in_power| × in_divisor to exactly one residual. in_power is two's complement and in_divisor is unsigned.
- R2: A power above zero feeds only the forward residual. A power below zero feeds only the reverse residual, with its magnitude; the most negative code gives magnitude 2^(PWR_W-1). A zero power changes neither residual.
- R3: The bucket size is {bkt_hi, bkt_lo}, an unsigned value of 2×WORD_W bits with bkt_hi as the upper word. Whenever a residual is at or above the bucket, one clock later the residual has dropped by exactly one bucket and its count has risen by exactly one.
- R4: An interval worth k buckets raises its count by one on each of k consecutive clocks. The first increment appears one clock after the transfer.
- R5: A transfer occurs only on a rising edge with in_valid and in_ready both high. in_ready is low whenever either residual is at or above a nonzero bucket.
- R6: Each count is CNT_W bits wide (24 by default) and wraps from all ones to zero.
- R7: clr is synchronous and has top priority. One clock after clr is high, both counts and both residuals are zero, and any transfer offered in that cycle is discarded.
- R8: A bucket of zero stops counting. in_ready stays high, accepted energy is discarded, and both counts hold.
- R9: rst_n is an active-low asynchronous reset. While it is low both counts are zero and, with a nonzero bucket, in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of counts and residuals |
| in_valid | input | 1 | Interval result offered |
| in_ready | output | 1 | Block can take an interval result |
| in_power | input | PWR_W | Signed average power of the interval |
| in_divisor | input | DIV_W | Number of samples in the interval |
| bkt_hi | input | WORD_W | Upper word of the bucket size |
| bkt_lo | input | WORD_W | Lower word of the bucket size |
| pos_cnt | output | CNT_W | Forward energy count |
| neg_cnt | output | CNT_W | Reverse energy count |

## Verification
The bench sends intervals worth ten buckets and watches the count rise by one per clock. A design that counted once per interval, or jumped by several, would fall behind or overshoot the reference. It offers a new transfer while the block is draining; a design that ignored back-pressure would lose energy or mix it into the wrong residual. Edge cases include the most negative power, a bucket that uses the upper word, a bucket of zero, a clear that collides with a transfer, and enough buckets to wrap a narrowed counter. Each would expose leftover residual, a dropped carry bit, a sign error or a missing wrap.

// File: rtl/eb_pkg.sv
package eb_pkg;

  typedef enum int {
    DIR_POS = 0,
    DIR_NEG = 1
  } eb_dir_e;

  localparam int EB_LANES = 2;

  function automatic int eb_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eb_energy_mult.sv
module eb_energy_mult #(
  parameter int PWR_W = 24,
  parameter int DIV_W = 24,
  parameter int EN_W  = PWR_W + DIV_W
) (
  input  logic signed [PWR_W-1:0] power,
  input  logic        [DIV_W-1:0] divisor,
  output logic        [EN_W-1:0]  energy,
  output logic                    is_pos,
  output logic                    is_neg
);

  logic [PWR_W-1:0] mag;

  always_comb begin
    is_neg = power[PWR_W-1];
    is_pos = !power[PWR_W-1] && (power != '0);
    mag    = is_neg ? PWR_W'(-power) : PWR_W'(power);
    energy = EN_W'(mag) * EN_W'(divisor);
  end

endmodule

// File: rtl/eb_residual_lane.sv
module eb_residual_lane #(
  parameter int BKT_W = 48,
  parameter int EN_W  = 48,
  parameter int RES_W = 49,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [EN_W-1:0]  add_val,
  input  logic [BKT_W-1:0] bucket,
  output logic             busy,
  output logic [CNT_W-1:0] count
);

  logic [RES_W-1:0] res;
  logic             bkt_nz;
  logic             over;

  always_comb begin
    bkt_nz = |bucket;
    over   = bkt_nz && (res >= RES_W'(bucket));
    busy   = over;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res   <= '0;
      count <= '0;
    end else if (clr) begin
      res   <= '0;
      count <= '0;
    end else if (add_en && bkt_nz) begin
      res <= res + RES_W'(add_val);
    end else if (over) begin
      res   <= res - RES_W'(bucket);
      count <= count + CNT_W'(1);
    end
  end

  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (res == '0 && count == '0));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

  // R8
  bkt_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bkt_nz && !clr) |=> $stable(count));

  // R5
  add_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |-> !over);

  // R3
  res_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (over && !clr && !add_en) |=> (res < $past(res)));

endmodule

// File: rtl/energy_bucket_counter.sv
module energy_bucket_counter
  import eb_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int PWR_W  = WORD_W,
  parameter int DIV_W  = WORD_W,
  parameter int CNT_W  = WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [PWR_W-1:0] in_power,
  input  logic        [DIV_W-1:0] in_divisor,
  input  logic       [WORD_W-1:0] bkt_hi,
  input  logic       [WORD_W-1:0] bkt_lo,
  output logic        [CNT_W-1:0] pos_cnt,
  output logic        [CNT_W-1:0] neg_cnt
);

  localparam int BKT_W = 2 * WORD_W;
  localparam int EN_W  = PWR_W + DIV_W;
  localparam int RES_W = eb_max(BKT_W, EN_W) + 1;

  logic [BKT_W-1:0]    bucket;
  logic [EN_W-1:0]     energy;
  logic                is_pos;
  logic                is_neg;
  logic                accept;
  logic [EB_LANES-1:0] lane_sel;
  logic [EB_LANES-1:0] lane_busy;
  logic [CNT_W-1:0]    lane_cnt [EB_LANES];

  assign bucket = {bkt_hi, bkt_lo};

  eb_energy_mult #(
    .PWR_W(PWR_W),
    .DIV_W(DIV_W),
    .EN_W (EN_W)
  ) u_mult (
    .power  (in_power),
    .divisor(in_divisor),
    .energy (energy),
    .is_pos (is_pos),
    .is_neg (is_neg)
  );

  always_comb begin
    lane_sel[int'(DIR_POS)] = is_pos;
    lane_sel[int'(DIR_NEG)] = is_neg;
    in_ready = ~|lane_busy;
    accept   = in_valid && in_ready && !clr;
  end

  for (genvar gi = 0; gi < EB_LANES; gi++) begin : g_lane
    eb_residual_lane #(
      .BKT_W(BKT_W),
      .EN_W (EN_W),
      .RES_W(RES_W),
      .CNT_W(CNT_W)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .add_en (accept && lane_sel[gi]),
      .add_val(energy),
      .bucket (bucket),
      .busy   (lane_busy[gi]),
      .count  (lane_cnt[gi])
    );
  end

  assign pos_cnt = lane_cnt[int'(DIR_POS)];
  assign neg_cnt = lane_cnt[int'(DIR_NEG)];

  // R2
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_pos, is_neg}));

  // R4
  one_lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !clr) |=> ($stable(pos_cnt) && $stable(neg_cnt)));

endmodule

// File: tb/tb_energy_bucket_counter.sv
module tb_energy_bucket_counter;

  localparam int WW  = 24;
  localparam int CW  = 8;
  localparam longint CMOD = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [WW-1:0] in_power = '0;
  logic [WW-1:0] in_divisor = '0;
  logic [WW-1:0] bkt_hi = '0;
  logic [WW-1:0] bkt_lo = 24'd1000;
  logic [CW-1:0] pos_cnt;
  logic [CW-1:0] neg_cnt;

  int errors = 0;
  int checks = 0;
  int acc_n = 0;
  bit done = 1'b0;

  longint m_pr = 0, m_nr = 0, m_pc = 0, m_nc = 0;
  bit m_rdy;

  energy_bucket_counter #(.WORD_W(WW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_ready(in_ready), .in_power(in_power), .in_divisor(in_divisor),
    .bkt_hi(bkt_hi), .bkt_lo(bkt_lo), .pos_cnt(pos_cnt), .neg_cnt(neg_cnt)
  );

  always #4 clk = ~clk;

  function automatic longint bkt_val();
    return (longint'(bkt_hi) << WW) | longint'(bkt_lo);
  endfunction

  function automatic bit model_ready();
    longint b = bkt_val();
    return !(b != 0 && (m_pr >= b || m_nr >= b));
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference, updated on every rising edge, compared shortly after
  always @(posedge clk) begin
    longint b, e, p;
    b = bkt_val();
    if (rst_n) begin
      if (clr) begin
        m_pr = 0; m_nr = 0; m_pc = 0; m_nc = 0;
      end else if (in_valid && model_ready()) begin
        acc_n++;
        p = longint'(in_power);
        e = (p < 0 ? -p : p) * longint'(in_divisor);
        if (b != 0) begin
          if (p > 0) m_pr += e;
          else if (p < 0) m_nr += e;
        end
      end else if (b != 0) begin
        if (m_pr >= b) begin m_pr -= b; m_pc = (m_pc + 1) % CMOD; end
        if (m_nr >= b) begin m_nr -= b; m_nc = (m_nc + 1) % CMOD; end
      end
      m_rdy = model_ready();
      #2;
      chk("R1 R3 R4 R6 forward count vs model", longint'(pos_cnt), m_pc);
      chk("R2 R3 R4 reverse count vs model", longint'(neg_cnt), m_nc);
      chk("R5 in_ready vs model", longint'(in_ready), longint'(model_ready()));
    end
  end

  task automatic send(longint p, longint d);
    int start;
    @(negedge clk);
    in_valid = 1'b1;
    in_power = WW'(p);
    in_divisor = WW'(d);
    start = acc_n;
    do @(negedge clk); while (acc_n == start);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!model_ready()) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R5 stall actual=running expected=finished");
      summary();
    end
  end

  initial begin
    #3;
    // R9 reset state
    chk("R9 forward count in reset", longint'(pos_cnt), 0);
    chk("R9 reverse count in reset", longint'(neg_cnt), 0);
    chk("R9 in_ready in reset", longint'(in_ready), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R3: two half buckets make one count with no remainder
    send(10, 50);
    send(10, 50);
    wait_idle();
    chk("R3 forward after 2x500", longint'(pos_cnt), 1);

    // R2 R5: reverse interval of 2100 drains two buckets
    send(-7, 300);
    chk("R5 in_ready low while draining", longint'(in_ready), 0);
    wait_idle();
    chk("R2 reverse after -2100", longint'(neg_cnt), 2);
    chk("R2 forward untouched", longint'(pos_cnt), 1);

    // R2 zero power, R4 ten buckets, back-to-back offer during drain
    send(0, 500);
    send(100, 100);
    send(-1, 900);
    wait_idle();
    chk("R4 forward after 10 buckets", longint'(pos_cnt), 11);
    chk("R4 reverse after back-pressured offer", longint'(neg_cnt), 3);

    // R3 upper bucket word, extreme powers
    @(negedge clk);
    bkt_hi = 24'd1;
    bkt_lo = 24'd0;
    send(64'sh7FFFFF, 3);
    send(-8388608, 2);
    wait_idle();
    chk("R3 forward with 2^24 bucket", longint'(pos_cnt), 12);
    chk("R2 reverse with most negative power", longint'(neg_cnt), 4);

    // R7 clear colliding with an offered transfer
    @(negedge clk);
    clr = 1'b1;
    in_valid = 1'b1;
    in_power = 24'sd50;
    in_divisor = 24'd50;
    @(negedge clk);
    clr = 1'b0;
    in_valid = 1'b0;
    chk("R7 forward cleared", longint'(pos_cnt), 0);
    chk("R7 reverse cleared", longint'(neg_cnt), 0);
    bkt_hi = 24'd0;
    bkt_lo = 24'd1000;
    send(999, 1);
    wait_idle();
    chk("R7 residual zero after clear", longint'(pos_cnt), 0);
    send(1, 1);
    wait_idle();
    chk("R7 exact bucket after clear", longint'(pos_cnt), 1);

    // R8 zero bucket discards energy
    @(negedge clk);
    bkt_lo = 24'd0;
    send(5, 5);
    send(-5, 5);
    wait_idle();
    chk("R8 forward held", longint'(pos_cnt), 1);
    chk("R8 reverse held", longint'(neg_cnt), 0);
    chk("R8 in_ready high", longint'(in_ready), 1);
    @(negedge clk);
    bkt_lo = 24'd1000;
    send(999, 1);
    wait_idle();
    chk("R8 energy discarded", longint'(pos_cnt), 1);

    // R6 wrap of narrowed counter
    pulse_clr();
    bkt_lo = 24'd1;
    send(1, 300);
    wait_idle();
    chk("R6 forward wrapped", longint'(pos_cnt), 44);

    done = 1'b1;
    summary();
  end

endmodule